// File: doc/BRIEF.md
# E-paper Serial Command/Data Framer

This block turns a stream of bytes into a write-only four-wire serial link toward an e-paper panel controller. The link has a serial clock, a serial data output, an active-low chip select and a data/command select line. Each frame is either a lone command byte, a lone data byte, a command byte followed by data bytes, or a run of data bytes only. The last form carries bulk pixel data. Whatever its length, a frame is sent under one chip-select assertion. The data/command line may change inside that assertion: it is low for the opening command byte and high for the data bytes behind it.

Bytes arrive through a valid/ready handshake. The frame type is taken with the first byte of a frame. For the two block types, a last flag on a byte closes the frame. The serial clock is the system clock divided by a parameter: each half-period lasts `CLK_DIV` system cycles, so the default of 5 gives 10 MHz from a 100 MHz system clock. The block shows busy while a frame is in flight and gives a one-cycle done pulse when chip select is released. The bus-select strap output is held low, which selects the four-wire serial mode.

Top module: `epd_spi_framer`

## Requirements
- R1: Kind code 2'b00 (single command) sends one byte with DC low at every rising SCLK edge. CSB then returns high with DC high at the same time.
- R2: Kind code 2'b01 (single data) sends one byte with DC high throughout. CSB is released after the eighth bit.
- R3: Kind code 2'b10 (command block) keeps CSB low for the whole frame. The first byte is sent with DC low and each later byte with DC high. The frame ends after the byte that carries byteLast=1.
- R4: Kind code 2'b11 (data-only block) streams every byte with DC high under one CSB assertion, up to and including the byte flagged last.
- R5: SPI mode 0 with MSB first: MOSI is sampled on the rising SCLK edge, bit 7 goes first, SCLK idles low, and MOSI only changes while SCLK is low.
- R6: Each SCLK high phase lasts exactly CLK_DIV system cycles, and so does each low phase inside a byte.
- R7: DC holds its value for at least CLK_DIV system cycles before the first rising SCLK edge of the byte it qualifies, and it does not change while SCLK is high.
- R8: byteReady is high only when the block is idle or waiting between bytes of a block. A byte is taken on a cycle with byteValid and byteReady both high. busy is high from that acceptance until CSB is released. done pulses for one cycle, in the cycle in which CSB returns high.
- R9: After reset, CSB and DC are high, SCLK is low, busy and done are low, byteReady is high, and busSel is always low.
- R10: For the single kinds (2'b00, 2'b01), byteLast is ignored: the frame is one byte long even when byteLast=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqKind | input | 2 | Frame type, sampled with the first byte of a frame |
| byteValid | input | 1 | Byte offered |
| byteData | input | DATA_W | Byte to send, MSB first |
| byteLast | input | 1 | Closes a block frame |
| byteReady | output | 1 | Byte can be accepted |
| spiSclk | output | 1 | Serial clock, idles low |
| spiMosi | output | 1 | Serial data out |
| spiCsb | output | 1 | Chip select, active low |
| spiDc | output | 1 | Low = command, high = data |
| busSel | output | 1 | Bus-select strap, constant low (4-wire) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |

## Verification
The framer is driven with each of the four frame kinds. A lone command and a lone data byte separate the two DC polarities and show that DC returns high after release. A command block with trailing data shows that DC changes inside a single CSB frame. A data-only burst with bit patterns 0x00, 0xFF, 0x81, 0x7E and 0x5A exposes bit-order and shift faults. Stalls between block bytes check that CSB stays low while the producer is slow. Single-kind frames offered with byteLast low, and a command block whose first byte is flagged last, pin down where frames end.

// File: rtl/epd_framer_pkg.sv
package epd_framer_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_LEAD = 3'd1,
    S_HIGH = 3'd2,
    S_WAIT = 3'd3,
    S_TAIL = 3'd4
  } framerState_t;

  // Frame kinds: bit1 = block, bit0 = first byte is data
  localparam logic [1:0] KIND_CMD      = 2'b00;
  localparam logic [1:0] KIND_DATA     = 2'b01;
  localparam logic [1:0] KIND_CMD_BLK  = 2'b10;
  localparam logic [1:0] KIND_DATA_BLK = 2'b11;

  typedef struct packed {
    logic loadByte;   // take a new byte, pull CSB low
    logic dcCmd;      // loaded byte is a command (DC low)
    logic shiftBit;   // advance to next bit on falling SCLK
    logic sclkRise;
    logic sclkFall;
    logic csbRelease; // end the frame, DC back to data
  } ctrlStrobes_t;

endpackage

// File: rtl/epd_framer_ctrl.sv
module epd_framer_ctrl
  import epd_framer_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   reqKind,
  input  logic         byteValid,
  input  logic         byteLast,
  output logic         byteReady,
  output logic         busy,
  output logic         done,
  output ctrlStrobes_t strobes
);

  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] HALF_LAST = CW'(CLK_DIV - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(DATA_W - 1);

  framerState_t state;
  logic [CW-1:0] halfCnt;
  logic [BW-1:0] bitCnt;
  logic          lastByte;
  logic          tick;
  logic          timed;

  assign timed     = (state == S_LEAD) || (state == S_HIGH) || (state == S_TAIL);
  assign tick      = timed && (halfCnt == HALF_LAST);
  assign byteReady = (state == S_IDLE) || (state == S_WAIT);
  assign busy      = (state != S_IDLE);

  always_comb begin
    strobes            = '0;
    strobes.loadByte   = byteReady && byteValid;
    strobes.dcCmd      = (state == S_IDLE) && !reqKind[0];
    strobes.sclkRise   = (state == S_LEAD) && tick;
    strobes.sclkFall   = (state == S_HIGH) && tick;
    strobes.shiftBit   = (state == S_HIGH) && tick && (bitCnt != BIT_LAST);
    strobes.csbRelease = (state == S_TAIL) && tick;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      halfCnt  <= '0;
      bitCnt   <= '0;
      lastByte <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (timed && !tick) halfCnt <= halfCnt + 1'b1;
      else                halfCnt <= '0;
      case (state)
        S_IDLE: if (byteValid) begin
          // single kinds end after one byte whatever byteLast says
          lastByte <= !reqKind[1] || byteLast;
          bitCnt   <= '0;
          state    <= S_LEAD;
        end
        S_LEAD: if (tick) state <= S_HIGH;
        S_HIGH: if (tick) begin
          if (bitCnt == BIT_LAST) begin
            state <= lastByte ? S_TAIL : S_WAIT;
          end else begin
            bitCnt <= bitCnt + 1'b1;
            state  <= S_LEAD;
          end
        end
        S_WAIT: if (byteValid) begin
          lastByte <= byteLast;
          bitCnt   <= '0;
          state    <= S_LEAD;
        end
        S_TAIL: if (tick) begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: an accepted first byte makes the block busy on the next cycle
  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && byteValid) |=> (busy && !byteReady));

  // R10: a single-kind frame never waits for a second byte
  p_single_no_wait_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && byteValid && !reqKind[1]) |=> lastByte);

endmodule

// File: rtl/epd_framer_dp.sv
module epd_framer_dp
  import epd_framer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] byteData,
  output logic              spiSclk,
  output logic              spiMosi,
  output logic              spiCsb,
  output logic              spiDc
);

  logic [DATA_W-1:0] shiftReg;

  assign spiMosi = shiftReg[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      spiSclk  <= 1'b0;
      spiCsb   <= 1'b1;
      spiDc    <= 1'b1;
    end else begin
      if (strobes.loadByte) begin
        shiftReg <= byteData;
        spiCsb   <= 1'b0;
        spiDc    <= !strobes.dcCmd;
      end else if (strobes.shiftBit) begin
        shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
      end
      if (strobes.sclkRise)      spiSclk <= 1'b1;
      else if (strobes.sclkFall) spiSclk <= 1'b0;
      if (strobes.csbRelease) begin
        spiCsb <= 1'b1;
        spiDc  <= 1'b1;
      end
    end
  end

  // R5: the serial clock only toggles inside a chip-select frame
  p_sclk_in_frame_r5: assert property (@(posedge clk) disable iff (!rstN)
    spiSclk |-> !spiCsb);

  // R5: data holds while the clock is high
  p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (spiSclk && $past(spiSclk)) |-> $stable(spiMosi));

  // R7: DC never moves during a high phase
  p_dc_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    spiSclk |-> $stable(spiDc));

  // R1: releasing chip select leaves DC at data level
  p_release_dc_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiCsb) |-> spiDc);

endmodule

// File: rtl/epd_spi_framer.sv
module epd_spi_framer
  import epd_framer_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        reqKind,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic              byteLast,
  output logic              byteReady,
  output logic              spiSclk,
  output logic              spiMosi,
  output logic              spiCsb,
  output logic              spiDc,
  output logic              busSel,
  output logic              busy,
  output logic              done
);

  ctrlStrobes_t strobes;

  assign busSel = 1'b0;

  epd_framer_ctrl #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqKind  (reqKind),
    .byteValid(byteValid),
    .byteLast (byteLast),
    .byteReady(byteReady),
    .busy     (busy),
    .done     (done),
    .strobes  (strobes)
  );

  epd_framer_dp #(.DATA_W(DATA_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .byteData(byteData),
    .spiSclk (spiSclk),
    .spiMosi (spiMosi),
    .spiCsb  (spiCsb),
    .spiDc   (spiDc)
  );

endmodule

// File: tb/tb_epd_spi_framer.sv
module tb_epd_spi_framer;

  localparam int CLK_DIV = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] reqKind = 2'b00;
  logic       byteValid = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic       byteLast = 1'b0;
  logic       byteReady, spiSclk, spiMosi, spiCsb, spiDc, busSel, busy, done;

  always #5 clk = ~clk;

  epd_spi_framer #(.DATA_W(8), .CLK_DIV(CLK_DIV)) dut (
    .clk(clk), .rstN(rstN), .reqKind(reqKind), .byteValid(byteValid),
    .byteData(byteData), .byteLast(byteLast), .byteReady(byteReady),
    .spiSclk(spiSclk), .spiMosi(spiMosi), .spiCsb(spiCsb), .spiDc(spiDc),
    .busSel(busSel), .busy(busy), .done(done)
  );

  typedef struct {
    logic [7:0] data;
    logic       dc;
    int         req;
  } expItem_t;

  expItem_t expQ[$];
  int       frameLenQ[$];
  int       frameReqQ[$];
  int       tests = 0;
  int       fails = 0;
  int       framesSent = 0;
  int       doneSeen = 0;
  bit       finished = 1'b0;

  task automatic check(input bit ok, input int req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: pushes expectations, then offers bytes through the handshake
  task automatic sendFrame(input logic [1:0] kind, input int n,
                           input logic [63:0] bytes, input logic singleLast,
                           input int req, input int gap);
    for (int i = 0; i < n; i++) begin
      expItem_t it;
      it.data = bytes[63-8*i -: 8];
      it.dc   = (kind == 2'b00) ? 1'b0 :
                (kind == 2'b10 && i == 0) ? 1'b0 : 1'b1;
      it.req  = req;
      expQ.push_back(it);
    end
    frameLenQ.push_back(n);
    frameReqQ.push_back(req);
    framesSent++;
    for (int i = 0; i < n; i++) begin
      if (i > 0) repeat (gap) @(negedge clk);
      @(negedge clk);
      reqKind   = kind;
      byteData  = bytes[63-8*i -: 8];
      byteLast  = kind[1] ? (i == n - 1) : singleLast;
      byteValid = 1'b1;
      while (!byteReady) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      byteValid = 1'b0;
      // R8: once a byte is taken, the block is busy and not ready
      check(busy && !byteReady, 8, "busy/ready after accept",
            {busy, byteReady}, 2'b10);
    end
  endtask

  // Monitor: models the panel side, sampled at the falling system edge
  initial begin
    logic prevSclk = 1'b0, prevCsb = 1'b1, prevDc = 1'b1;
    int   bitIdx = 0, dcAge = 1000, highLen = 0, lowLen = 0, bytesInFrame = 0;
    logic [7:0] cur = 8'h00;
    logic dcFirst = 1'b1, dcMixed = 1'b0;
    forever begin
      @(negedge clk);
      if (!rstN) continue;
      if (done) doneSeen++;
      if (spiDc != prevDc) dcAge = 1; else dcAge++;
      if (spiSclk) highLen++; else lowLen++;
      if (spiSclk && !prevSclk) begin
        // R7: DC settled at least one half-period before this rise
        if (bitIdx == 0)
          check(dcAge >= CLK_DIV, 7, "DC settle cycles", dcAge, CLK_DIV);
        if (bitIdx > 0)
          check(lowLen == CLK_DIV, 6, "SCLK low phase", lowLen, CLK_DIV);
        if (bitIdx == 0) begin dcFirst = spiDc; dcMixed = 1'b0; end
        else if (spiDc != dcFirst) dcMixed = 1'b1;
        cur = {cur[6:0], spiMosi};
        bitIdx++;
        highLen = 1;
      end
      if (!spiSclk && prevSclk) begin
        // R6: high phase is exactly CLK_DIV system cycles
        check(highLen == CLK_DIV, 6, "SCLK high phase", highLen, CLK_DIV);
        lowLen = 1;
        if (bitIdx == 8) begin
          expItem_t e;
          bitIdx = 0;
          bytesInFrame++;
          if (expQ.size() == 0) begin
            check(1'b0, 5, "unexpected byte", cur, 0);
          end else begin
            e = expQ.pop_front();
            // R5: MSB-first byte value
            check(cur == e.data, e.req, "byte value", cur, e.data);
            check(!dcMixed && dcFirst == e.dc, e.req, "DC level",
                  {dcMixed, dcFirst}, {1'b0, e.dc});
          end
        end
      end
      if (spiCsb && !prevCsb) begin
        int expLen = 0, r = 0;
        if (frameLenQ.size() > 0) begin
          expLen = frameLenQ.pop_front();
          r = frameReqQ.pop_front();
        end
        check(bytesInFrame == expLen, r, "bytes in CSB frame", bytesInFrame, expLen);
        // R8: done in the same cycle CSB returns high; R1: DC back high
        check(done == 1'b1, 8, "done at release", done, 1);
        check(spiDc == 1'b1, 1, "DC idle high after frame", spiDc, 1);
        check(bitIdx == 0, 5, "whole bytes only", bitIdx, 0);
        bytesInFrame = 0;
      end
      prevSclk = spiSclk; prevCsb = spiCsb; prevDc = spiDc;
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual=expired expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9: reset state
    check(spiCsb && spiDc && !spiSclk && !busy && !done && byteReady && !busSel,
          9, "reset outputs",
          {spiCsb, spiDc, spiSclk, busy, done, byteReady, busSel}, 7'b1100010);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(spiCsb && spiDc && !busy && byteReady && !busSel, 9, "idle after reset",
          {spiCsb, spiDc, busy, byteReady, busSel}, 5'b11010);

    // R1 (with byteLast low, also R10)
    sendFrame(2'b00, 1, {8'hA5, 56'h0}, 1'b0, 1, 0);
    // R2
    sendFrame(2'b01, 1, {8'h3C, 56'h0}, 1'b1, 2, 0);
    // R3: command followed by two data bytes, no stall
    sendFrame(2'b10, 3, {8'h50, 8'hA9, 8'h07, 40'h0}, 1'b0, 3, 0);
    // R4: data-only burst with varied bit patterns
    sendFrame(2'b11, 5, {8'h00, 8'hFF, 8'h81, 8'h7E, 8'h5A, 24'h0}, 1'b0, 4, 0);
    // R3: stall between block bytes keeps CSB low
    sendFrame(2'b10, 4, {8'h13, 8'hC3, 8'h0F, 8'hF0, 32'h0}, 1'b0, 3, 37);
    // R3: command block closed on its first byte
    sendFrame(2'b10, 1, {8'h92, 56'h0}, 1'b0, 3, 0);
    // R10: single data with byteLast low still ends after one byte
    sendFrame(2'b01, 1, {8'h96, 56'h0}, 1'b0, 10, 0);
    // R4: data-only burst with a stall
    sendFrame(2'b11, 3, {8'h01, 8'h80, 8'hAA, 40'h0}, 1'b0, 4, 20);

    while (busy || expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(frameLenQ.size() == 0, 3, "all frames closed", frameLenQ.size(), 0);
    // R8: exactly one done pulse per frame
    check(doneSeen == framesSent, 8, "done pulse count", doneSeen, framesSent);
    check(!busy && byteReady && spiCsb && !spiSclk, 9, "idle at end",
          {busy, byteReady, spiCsb, spiSclk}, 4'b0110);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule